// File: doc/BRIEF.md
# Serial Register Bank for an Eight-Channel Load Switch

This block is the digital control slice of an eight-channel load-switch controller. A host talks to it over a four-wire serial link (chip select, serial clock, serial data in, serial data out with an output enable). Each 16-bit frame either writes one 4-bit control register, asks for one register to be returned, or does nothing. The reply to a frame is shifted out during the following frame. Every channel has a 2-bit source selector that picks one of four drive sources for the channel-on output: forced off, external drive input A, external drive input B, or forced on. Every channel also has a diagnosis-current enable bit.

Fault pulses from the channel sensors are kept in sticky per-channel flags. A command bit empties the flags and keeps them empty until the next accepted frame, at which point it drops by itself. While the fail-safe input is high, all writable state is held at its default and every write is refused. Status and flag reads still answer, so the host can see why its commands have no effect. Standby and reset command bits return the control registers to their defaults. Data entering on the serial input leaves on the serial output 16 bit times later, so several devices that share one chip select form a single long shift chain.

Top module: `spi_switch_regbank`

## Requirements
- R1: While chip select (active low) is high, the serial output enable is low, and serial clock and data activity changes no register.
- R2: A frame is shifted MSB first, with the input sampled on rising serial-clock edges. It is acted on at the rising edge of chip select only if exactly 16 rising clock edges occurred. Any other count leaves all state unchanged.
- R3: Command frame fields: bits [15:14] are the operation (00 none, 01 read control register, 10 read diagnosis register, 11 write control register), bits [13:11] are the register address, and bits [3:0] are the write data. Control register a (0 to 3) holds the selector of channel 2a in bits [1:0] and of channel 2a+1 in bits [3:2].
- R4: Selector code 00 drives the channel-on output low, 01 makes it follow drive input A, 10 makes it follow drive input B, and 11 drives it high.
- R5: Control register 4 holds the diagnosis-current enables of channels 0 to 3 and register 5 those of channels 4 to 7, bit n for channel base+n; 1 enables the current.
- R6: After reset every control register, every flag and every enable is 0, the output enable is low, and the first reply frame is 0x0000.
- R7: A fault pulse on a channel sets that channel's flag, and the flag stays set after the pulse. A reply following an operation other than a read is a diagnosis frame: bit 15 = 0, bit 14 = fail-safe level, bits [7:0] = flags.
- R8: Writing control register 7 with bit 0 set empties all flags and ignores new faults until the next accepted frame. That frame clears the bit, and faults latch again after it.
- R9: While the fail-safe input is high, all control registers are held at 0, every write is refused and the channel outputs are low. Diagnosis replies show bit 14 = 1, and reads still answer. The registers stay at 0 after the input falls, and writes are accepted again.
- R10: Writing control register 7 with bit 1 (standby) or bit 2 (reset) set returns control registers 0 to 5 to 0.
- R11: A reply following a read has bit 15 = 1, bit 14 = bank (1 for diagnosis), bits [13:11] = the address, and bits [3:0] = the data. Diagnosis register 0 holds flags 0 to 3, register 1 holds flags 4 to 7, and register 2 holds the fail-safe level in bit 0.
- R12: Bits entering on the serial input appear on the serial output 16 serial-clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data out driver |
| drv_a_i | input | 1 | External drive input A |
| drv_b_i | input | 1 | External drive input B |
| failsafe_i | input | 1 | Fail-safe request, active high |
| fault_i | input | 8 | Per-channel fault pulses |
| chan_on_o | output | 8 | Per-channel switch-on decision |
| dcur_en_o | output | 8 | Per-channel diagnosis-current enable |

## Verification
Three functions can land in the same cycle. A fault pulse can arrive while the flag-clear bit is still pending. The fail-safe input can rise while the host's write frames continue. The frame that ends a clear can coincide with new faults. The bench pulses faults between the clear command and the next frame and expects an empty diagnosis reply. It then pulses a fault after that frame and expects the flag to return. It raises fail-safe, sends writes and reads, and judges the refused writes by the channel outputs and by read-back of the registers.

// File: rtl/sw_rb_pkg.sv
package sw_rb_pkg;

    typedef enum logic [1:0] {
        OP_NOP     = 2'b00,
        OP_RD_CTRL = 2'b01,
        OP_RD_DIAG = 2'b10,
        OP_WRITE   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_A   = 2'b01,
        SRC_B   = 2'b10,
        SRC_ON  = 2'b11
    } src_e;

    localparam int CMD_BIT_CLR  = 0;
    localparam int CMD_BIT_STBY = 1;
    localparam int CMD_BIT_RST  = 2;

endpackage

// File: rtl/sw_rb_sync.sv
module sw_rb_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q, stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[b];
                    stab_q <= RST_VAL[b];
                end else begin
                    meta_q <= async_i[b];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[b] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/sw_rb_shifter.sv
module sw_rb_shifter
    import sw_rb_pkg::*;
#(
    parameter int FW = 16,
    parameter int AW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          sclk_i,
    input  logic          si_i,
    input  logic [FW-1:0] resp_i,
    output logic          so_o,
    output logic          so_oe_o,
    output logic          commit_o,
    output op_e           op_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    localparam int CNT_W = $clog2(FW + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

    typedef struct packed {
        logic             cs_p;
        logic             sclk_p;
        logic             bit_q;
        logic [FW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t st_d, st_q;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall;

    always_comb begin
        st_d        = st_q;
        st_d.cs_p   = cs_i;
        st_d.sclk_p = sclk_i;
        cs_fall     = st_q.cs_p & ~cs_i;
        cs_rise     = ~st_q.cs_p & cs_i;
        sclk_rise   = sclk_i & ~st_q.sclk_p;
        sclk_fall   = ~sclk_i & st_q.sclk_p;
        if (cs_fall) begin
            st_d.sh  = resp_i;
            st_d.cnt = '0;
        end else if (!cs_i) begin
            if (sclk_rise) begin
                st_d.bit_q = si_i;
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (sclk_fall) begin
                st_d.sh = {st_q.sh[FW-2:0], st_q.bit_q};
            end
        end
        commit_o = cs_rise && (st_q.cnt == CNT_FULL);
        op_o     = op_e'(st_q.sh[FW-1 -: 2]);
        addr_o   = st_q.sh[FW-3 -: AW];
        data_o   = st_q.sh[DW-1:0];
        so_o     = st_q.sh[FW-1];
        so_oe_o  = ~cs_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sw_rb_regs.sv
module sw_rb_regs
    import sw_rb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int FW  = 16,
    parameter int AW  = 3,
    parameter int DW  = 4,
    parameter int DAW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  op_e              op_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic             limp_i,
    input  logic [NCH-1:0]   fault_i,
    output logic [2*NCH-1:0] sel_o,
    output logic [NCH-1:0]   en_o,
    output logic [NCH-1:0]   flags_o,
    output logic             clr_o,
    output logic [FW-1:0]    resp_o
);
    localparam int N_SEL   = (2 * NCH) / DW;
    localparam int N_EN    = NCH / DW;
    localparam int EN_BASE = N_SEL;
    localparam int N_FLAG  = NCH / DW;
    localparam logic [AW-1:0] CMD_A = '1;
    localparam int PAD_RD  = FW - 2 - AW - DW;
    localparam int PAD_STD = FW - 2 - NCH;

    typedef struct packed {
        logic [2*NCH-1:0] sel;
        logic [NCH-1:0]   en;
        logic [NCH-1:0]   flags;
        logic             clr;
        op_e              rop;
        logic [AW-1:0]    raddr;
    } bank_t;

    bank_t st_d, st_q;
    logic [DW-1:0] ctrl_rd, diag_rd;

    always_comb begin
        st_d       = st_q;
        st_d.flags = st_q.clr ? '0 : (st_q.flags | fault_i);
        if (commit_i) begin
            st_d.clr   = 1'b0;
            st_d.rop   = op_i;
            st_d.raddr = addr_i;
            if (op_i == OP_WRITE && !limp_i) begin
                for (int a = 0; a < N_SEL; a++) begin
                    if (addr_i == AW'(a)) st_d.sel[a*DW +: DW] = data_i;
                end
                for (int e = 0; e < N_EN; e++) begin
                    if (addr_i == AW'(EN_BASE + e)) st_d.en[e*DW +: DW] = data_i;
                end
                if (addr_i == CMD_A) begin
                    st_d.clr = data_i[CMD_BIT_CLR];
                    if (data_i[CMD_BIT_STBY] || data_i[CMD_BIT_RST]) begin
                        st_d.sel = '0;
                        st_d.en  = '0;
                    end
                end
            end
        end
        if (limp_i) begin
            st_d.sel = '0;
            st_d.en  = '0;
            st_d.clr = 1'b0;
        end
    end

    always_comb begin
        ctrl_rd = '0;
        for (int a = 0; a < N_SEL; a++) begin
            if (st_q.raddr == AW'(a)) ctrl_rd = st_q.sel[a*DW +: DW];
        end
        for (int e = 0; e < N_EN; e++) begin
            if (st_q.raddr == AW'(EN_BASE + e)) ctrl_rd = st_q.en[e*DW +: DW];
        end
        if (st_q.raddr == CMD_A) ctrl_rd = {{(DW-1){1'b0}}, st_q.clr};

        diag_rd = '0;
        for (int f = 0; f < N_FLAG; f++) begin
            if (st_q.raddr[DAW-1:0] == DAW'(f)) diag_rd = st_q.flags[f*DW +: DW];
        end
        if (st_q.raddr[DAW-1:0] == DAW'(N_FLAG)) diag_rd = {{(DW-1){1'b0}}, limp_i};

        case (st_q.rop)
            OP_RD_CTRL: resp_o = {1'b1, 1'b0, st_q.raddr, {PAD_RD{1'b0}}, ctrl_rd};
            OP_RD_DIAG: resp_o = {1'b1, 1'b1, st_q.raddr, {PAD_RD{1'b0}}, diag_rd};
            default:    resp_o = {1'b0, limp_i, {PAD_STD{1'b0}}, st_q.flags};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rop <= OP_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o   = st_q.sel;
    assign en_o    = st_q.en;
    assign flags_o = st_q.flags;
    assign clr_o   = st_q.clr;
endmodule

// File: rtl/sw_rb_chan_mux.sv
module sw_rb_chan_mux
    import sw_rb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [2*NCH-1:0] sel_i,
    input  logic             a_i,
    input  logic             b_i,
    output logic [NCH-1:0]   on_o
);
    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            src_e src;
            assign src = src_e'(sel_i[2*ch +: 2]);
            always_comb begin
                case (src)
                    SRC_A:   on_o[ch] = a_i;
                    SRC_B:   on_o[ch] = b_i;
                    SRC_ON:  on_o[ch] = 1'b1;
                    default: on_o[ch] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/spi_switch_regbank.sv
module spi_switch_regbank
    import sw_rb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int FW  = 16,
    parameter int AW  = 3,
    parameter int DW  = 4,
    parameter int DAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n_i,
    input  logic           sclk_i,
    input  logic           sdi_i,
    output logic           sdo_o,
    output logic           sdo_oe_o,
    input  logic           drv_a_i,
    input  logic           drv_b_i,
    input  logic           failsafe_i,
    input  logic [NCH-1:0] fault_i,
    output logic [NCH-1:0] chan_on_o,
    output logic [NCH-1:0] dcur_en_o
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] sync_w;
    logic cs_s, sclk_s, si_s, limp_s, a_s, b_s;
    logic commit_w;
    op_e  op_w;
    logic [AW-1:0]    addr_w;
    logic [DW-1:0]    data_w;
    logic [FW-1:0]    resp_w;
    logic [2*NCH-1:0] sel_w;
    logic [NCH-1:0]   flags_w;
    logic             clr_w;

    sw_rb_sync #(.W(NSYNC), .RST_VAL(6'b000001)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({drv_b_i, drv_a_i, failsafe_i, sdi_i, sclk_i, cs_n_i}),
        .sync_o (sync_w)
    );
    assign {b_s, a_s, limp_s, si_s, sclk_s, cs_s} = sync_w;

    sw_rb_shifter #(.FW(FW), .AW(AW), .DW(DW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_s),
        .sclk_i  (sclk_s),
        .si_i    (si_s),
        .resp_i  (resp_w),
        .so_o    (sdo_o),
        .so_oe_o (sdo_oe_o),
        .commit_o(commit_w),
        .op_o    (op_w),
        .addr_o  (addr_w),
        .data_o  (data_w)
    );

    sw_rb_regs #(.NCH(NCH), .FW(FW), .AW(AW), .DW(DW), .DAW(DAW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit_w),
        .op_i    (op_w),
        .addr_i  (addr_w),
        .data_i  (data_w),
        .limp_i  (limp_s),
        .fault_i (fault_i),
        .sel_o   (sel_w),
        .en_o    (dcur_en_o),
        .flags_o (flags_w),
        .clr_o   (clr_w),
        .resp_o  (resp_w)
    );

    sw_rb_chan_mux #(.NCH(NCH)) u_mux (
        .sel_i(sel_w),
        .a_i  (a_s),
        .b_i  (b_s),
        .on_o (chan_on_o)
    );
endmodule

// File: rtl/spi_switch_regbank_chk.sv
module spi_switch_regbank_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             cs_s,
    input logic             limp_s,
    input logic             sdo_oe_o,
    input logic             clr_w,
    input logic [NCH-1:0]   flags_w,
    input logic [2*NCH-1:0] sel_w,
    input logic [NCH-1:0]   dcur_en_o,
    input logic [NCH-1:0]   chan_on_o
);
    // R1: a select held high for three cycles leaves the output disabled
    assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !sdo_oe_o);

    // R1: no register write without a select rise
    assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s) && !limp_s) |=> $stable({sel_w, dcur_en_o}));

    // R9: fail-safe forces every channel and enable off
    assert_limp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        limp_s |=> (chan_on_o == '0 && dcur_en_o == '0));

    // R7: flags never drop while no clear is pending
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_w |=> (($past(flags_w) & ~flags_w) == '0));

    // R8: a pending clear empties the flags
    assert_clr_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (flags_w == '0));
endmodule

bind spi_switch_regbank spi_switch_regbank_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .cs_s     (cs_s),
    .limp_s   (limp_s),
    .sdo_oe_o (sdo_oe_o),
    .clr_w    (clr_w),
    .flags_w  (flags_w),
    .sel_w    (sel_w),
    .dcur_en_o(dcur_en_o),
    .chan_on_o(chan_on_o)
);

// File: tb/spi_switch_regbank_tb_top.sv
module spi_switch_regbank_tb_top;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       drv_a = 1'b0, drv_b = 1'b0, failsafe = 1'b0;
    logic [7:0] fault = '0;
    logic       sdo, sdo_oe;
    logic [7:0] chan_on, dcur_en;

    int checks = 0;
    int fails  = 0;
    logic [15:0] sel_m = '0;
    logic [7:0]  en_m  = '0;

    always #10 clk = ~clk;

    spi_switch_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .drv_a_i(drv_a), .drv_b_i(drv_b),
        .failsafe_i(failsafe), .fault_i(fault), .chan_on_o(chan_on), .dcur_en_o(dcur_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b0;
        waitn(HALF);
        for (int i = 0; i < n; i++) begin
            sdi = tx[n-1-i];
            waitn(HALF);
            rx = {rx[30:0], sdo};
            sclk = 1'b1;
            waitn(HALF);
            sclk = 1'b0;
        end
        waitn(HALF);
        cs_n = 1'b1;
        waitn(2 * HALF);
    endtask

    function automatic logic [15:0] frame(input logic [1:0] op, input logic [2:0] a, input logic [3:0] d);
        return {op, a, 7'b0, d};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        logic [31:0] rx;
        xfer({16'h0, frame(2'b11, a, d)}, 16, rx);
        if (!failsafe) begin
            if (a < 4) sel_m[a*4 +: 4] = d;
            else if (a == 4) en_m[3:0] = d;
            else if (a == 5) en_m[7:4] = d;
            else if (a == 7 && (d[1] || d[2])) begin sel_m = '0; en_m = '0; end
        end
    endtask

    task automatic get_resp(input logic [1:0] op, input logic [2:0] a, output logic [15:0] r);
        logic [31:0] rx;
        xfer({16'h0, frame(op, a, 4'h0)}, 16, rx);
        xfer({16'h0, frame(2'b00, 3'd0, 4'h0)}, 16, rx);
        r = rx[15:0];
    endtask

    function automatic logic [7:0] exp_on(input logic [15:0] s, input logic a, input logic b);
        logic [7:0] o;
        for (int c = 0; c < 8; c++) begin
            case (s[2*c +: 2])
                2'b01:   o[c] = a;
                2'b10:   o[c] = b;
                2'b11:   o[c] = 1'b1;
                default: o[c] = 1'b0;
            endcase
        end
        return o;
    endfunction

    task automatic t_reset;
        logic [31:0] rx;
        chk(sdo_oe == 1'b0, "R6 oe after reset", sdo_oe, 0);
        chk(chan_on == 8'h00, "R6 chan_on after reset", chan_on, 0);
        chk(dcur_en == 8'h00, "R6 dcur after reset", dcur_en, 0);
        xfer({16'h0, frame(2'b00, 3'd0, 4'h0)}, 16, rx);
        chk(rx[15:0] == 16'h0000, "R6 first reply", rx[15:0], 0);
    endtask

    task automatic t_write_read;
        logic [15:0] r;
        wr(3'd0, 4'b1101);
        get_resp(2'b01, 3'd0, r);
        chk(r == 16'h800D, "R3 R11 read control 0", r, 16'h800D);
        wr(3'd3, 4'b1100);
        get_resp(2'b01, 3'd3, r);
        chk(r == 16'h980C, "R3 R11 read control 3", r, 16'h980C);
    endtask

    task automatic t_mux;
        wr(3'd0, 4'b1101);
        wr(3'd1, 4'b1000);
        wr(3'd2, 4'b0110);
        wr(3'd3, 4'b1100);
        for (int ab = 0; ab < 4; ab++) begin
            drv_a = ab[0];
            drv_b = ab[1];
            waitn(4);
            chk(chan_on == exp_on(sel_m, drv_a, drv_b), "R4 source mux", chan_on, exp_on(sel_m, drv_a, drv_b));
        end
    endtask

    task automatic t_dcur;
        logic [15:0] r;
        wr(3'd4, 4'b1010);
        wr(3'd5, 4'b0101);
        chk(dcur_en == 8'b0101_1010, "R5 current enables", dcur_en, 8'b0101_1010);
        get_resp(2'b01, 3'd5, r);
        chk(r == 16'hA805, "R5 read enables hi", r, 16'hA805);
    endtask

    task automatic t_cs_high;
        logic [15:0] r;
        logic [7:0]  on_before;
        bit          oe_seen = 1'b0;
        on_before = chan_on;
        for (int i = 0; i < 40; i++) begin
            sdi = i[0];
            waitn(3);
            sclk = ~sclk;
            waitn(3);
            if (sdo_oe) oe_seen = 1'b1;
        end
        sclk = 1'b0;
        waitn(6);
        chk(!oe_seen, "R1 output disabled while idle", oe_seen, 0);
        chk(chan_on == on_before, "R1 channels unchanged", chan_on, on_before);
        chk(dcur_en == en_m, "R1 enables unchanged", dcur_en, en_m);
        get_resp(2'b01, 3'd4, r);
        chk(r == {12'hA00, en_m[3:0]}, "R1 register unchanged", r, {12'hA00, en_m[3:0]});
    endtask

    task automatic t_bad_len;
        logic [31:0] rx;
        logic [15:0] f;
        f = frame(2'b11, 3'd4, 4'b0000);
        xfer({17'h0, f[15:1]}, 15, rx);
        chk(dcur_en == en_m, "R2 short frame ignored", dcur_en, en_m);
        xfer({15'h0, f, 1'b0}, 17, rx);
        chk(dcur_en == en_m, "R2 long frame ignored", dcur_en, en_m);
        wr(3'd4, 4'b0000);
        chk(dcur_en == en_m, "R2 full frame accepted", dcur_en, en_m);
    endtask

    task automatic t_daisy;
        logic [31:0] rx;
        logic [15:0] fa;
        fa = frame(2'b11, 3'd5, 4'b1111);
        xfer({fa, 16'h3C5A}, 32, rx);
        chk(rx[15:0] == fa, "R12 chain pass-through", rx[15:0], fa);
        chk(dcur_en == en_m, "R2 chained frame ignored", dcur_en, en_m);
    endtask

    task automatic t_flags;
        logic [15:0] r;
        fault = 8'h44;
        waitn(1);
        fault = 8'h00;
        waitn(4);
        get_resp(2'b00, 3'd0, r);
        chk(r == 16'h0044, "R7 flags latched", r, 16'h0044);
        get_resp(2'b10, 3'd1, r);
        chk(r == 16'hC804, "R11 read diagnosis 1", r, 16'hC804);
    endtask

    task automatic t_clear;
        logic [15:0] r;
        wr(3'd7, 4'b0001);
        waitn(3);
        fault = 8'h01;
        waitn(1);
        fault = 8'h00;
        waitn(3);
        get_resp(2'b00, 3'd0, r);
        chk(r == 16'h0000, "R8 flags emptied and held", r, 16'h0000);
        fault = 8'h02;
        waitn(1);
        fault = 8'h00;
        waitn(3);
        get_resp(2'b00, 3'd0, r);
        chk(r == 16'h0002, "R8 clear dropped after frame", r, 16'h0002);
    endtask

    task automatic t_limp;
        logic [15:0] r;
        wr(3'd1, 4'b1111);
        chk(chan_on[3:2] == 2'b11, "R9 setup", chan_on, 8'h0C);
        failsafe = 1'b1;
        sel_m = '0;
        en_m  = '0;
        waitn(6);
        chk(chan_on == 8'h00 && dcur_en == 8'h00, "R9 outputs off", {dcur_en, chan_on}, 0);
        wr(3'd0, 4'b1111);
        chk(chan_on == 8'h00, "R9 write refused", chan_on, 0);
        get_resp(2'b00, 3'd0, r);
        chk(r == 16'h4002, "R9 status bit in reply", r, 16'h4002);
        get_resp(2'b01, 3'd1, r);
        chk(r == 16'h8800, "R9 control read answers", r, 16'h8800);
        get_resp(2'b10, 3'd2, r);
        chk(r == 16'hD001, "R9 R11 status register", r, 16'hD001);
        failsafe = 1'b0;
        waitn(6);
        chk(chan_on == 8'h00, "R9 stays reset after exit", chan_on, 0);
        wr(3'd0, 4'b0011);
        chk(chan_on == 8'h01, "R9 writes accepted after exit", chan_on, 8'h01);
    endtask

    task automatic t_standby;
        wr(3'd4, 4'hF);
        wr(3'd2, 4'b1111);
        chk(dcur_en[3:0] == 4'hF && chan_on[5:4] == 2'b11, "R10 setup", {dcur_en, chan_on}, 16'h0F31);
        wr(3'd7, 4'b0010);
        chk(dcur_en == 8'h00 && chan_on == 8'h00, "R10 standby resets", {dcur_en, chan_on}, 0);
        wr(3'd5, 4'hF);
        wr(3'd1, 4'b1100);
        wr(3'd7, 4'b0100);
        chk(dcur_en == 8'h00 && chan_on == 8'h00, "R10 reset command", {dcur_en, chan_on}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        waitn(5);
        rst_n = 1'b1;
        waitn(5);
        t_reset();
        t_write_read();
        t_mux();
        t_dcur();
        t_cs_high();
        t_bad_len();
        t_daisy();
        t_flags();
        t_clear();
        t_limp();
        t_standby();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule